// File: doc/BRIEF.md
# PCI I/O Target Port

This block is the target side of a PCI bus attachment that serves single-data-phase I/O reads and writes to a small bank of local registers. It watches for the start of each bus transaction, latches the address and command, and decides on the following clock whether the access belongs to it. The access must be an I/O read or an I/O write, and it must fall inside a parameterised I/O window. A claimed access is acknowledged with a device-select, held for a fixed number of wait states, and then finished with target-ready. Reads return data from the local register port together with parity. Writes hand the bus data to the local register port.

On the local side the block presents a byte offset inside the window, byte enables, a one-clock read strobe, a one-clock write strobe and the write data. Read data is expected combinationally while the read strobe is high. On the bus side the initiator's IRDY and the block's TRDY form the handshake. TRDY plays the part of ready and IRDY the part of valid. Once TRDY is asserted the block holds it, and holds its read data, for as many clocks as the initiator withholds IRDY. The transfer completes on the first clock edge where both are sampled low.

The block stops decoding while its own device is driving the bus as master, and it stops decoding while I/O space is disabled. An initiator that tries to extend the access into a burst is disconnected with STOP.

Top module: `pci_io_target`

## Requirements
- R1: While `io_enable` is low on the edge where FRAME is first sampled low, the access is not claimed: DEVSEL stays deasserted and neither register strobe fires.
- R2: Only commands 4'b0010 (I/O read) and 4'b0011 (I/O write), driven active-low on C/BE during the address phase, are claimed. Any other command, and any address outside the window, leaves DEVSEL deasserted.
- R3: DEVSEL goes low on the clock edge after the edge where FRAME is first sampled low.
- R4: TRDY goes low exactly WAIT_STATES clocks after DEVSEL goes low (6 by default). For a read, AD carries the register data with `ad_oe` high from that edge.
- R5: A claimed read pulses `reg_rd` for one clock, starting on the DEVSEL edge. During that clock `reg_addr` holds the offset and `reg_be` holds the inverted C/BE of the first data clock. `reg_rdata` is captured at the end of that clock.
- R6: A claimed write pulses `reg_wr` for one clock, starting on the completing edge. It carries the AD value and the inverted C/BE sampled on that edge, together with the offset.
- R7: TRDY stays low until IRDY is sampled low. Completion happens on the first edge where both are sampled low.
- R8: If FRAME is still low when TRDY is asserted, or at any time while waiting for IRDY, STOP is driven low together with TRDY.
- R9: On reads, `par_out` is driven with `par_oe` high one clock after each AD data clock. Its value makes the count of ones over AD[31:0], C/BE[3:0] and PAR even.
- R10: On the completing edge, `ad_oe` drops and DEVSEL, TRDY and STOP are driven high for one clock with `ctl_oe` high. On the next edge `ctl_oe` drops.
- R11: While `master_active` is high on the edge where FRAME is first sampled low, the access is not claimed.
- R12: The window match compares only address bits above WIN_BITS. `reg_addr` is the low WIN_BITS bits of the address phase.
- R13: A new FRAME sampled on the turnaround edge after a completion is decoded and claimed with the same timing as from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| io_enable | input | 1 | I/O space enable from the command register |
| master_active | input | 1 | High while this device owns the bus as master |
| frame_n | input | 1 | FRAME from the bus |
| irdy_n | input | 1 | IRDY from the bus |
| cbe_n_in | input | 4 | C/BE lines from the bus |
| ad_in | input | 32 | AD lines from the bus |
| ad_out | output | 32 | Read data to AD |
| ad_oe | output | 1 | Output enable for AD |
| par_out | output | 1 | PAR value for read data |
| par_oe | output | 1 | Output enable for PAR |
| devsel_n_out | output | 1 | DEVSEL drive value |
| trdy_n_out | output | 1 | TRDY drive value |
| stop_n_out | output | 1 | STOP drive value |
| ctl_oe | output | 1 | Output enable for DEVSEL, TRDY and STOP |
| reg_addr | output | WIN_BITS | Byte offset inside the window |
| reg_be | output | 4 | Active-high byte enables |
| reg_rd | output | 1 | One-clock read strobe |
| reg_wr | output | 1 | One-clock write strobe |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid while reg_rd is high |

## Verification
Two functions can fall on the same clock edge: the control turnaround that releases DEVSEL, TRDY and STOP after a completion, and the sampling of a new FRAME for the next access. The bench provokes this by starting a read on the very clock after a write completes. The write strobe is still high on that clock and the released controls are still driven high. The second access is judged by the same DEVSEL and TRDY edge counts as an access started from idle, and by the read data it returns. A second overlap comes from holding FRAME low into the data phase: STOP must then appear on the same edge as TRDY.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_WAIT,
    ST_DATA,
    ST_TURN
  } tgt_state_e;

  localparam logic [3:0] CMD_IO_RD = 4'b0010;
  localparam logic [3:0] CMD_IO_WR = 4'b0011;

  // even parity: the returned bit makes the total count of ones even
  function automatic logic even_par(input logic [31:0] d, input logic [3:0] c);
    return ^{d, c};
  endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0000_C000,
  parameter int          WIN_BITS  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_enable,
  input  logic                master_active,
  input  logic                frame_n,
  input  logic [31:0]         ad_in,
  input  logic [3:0]          cbe_n,
  input  logic                can_start,
  output logic                start,
  output logic                hit,
  output logic                is_rd,
  output logic [WIN_BITS-1:0] offset
);

  logic        frame_q;
  logic [31:0] addr_q;
  logic [3:0]  cmd_q;
  logic        in_win;
  logic        io_cmd;

  // first edge with FRAME low after it was high
  assign start = can_start & ~frame_n & frame_q & io_enable & ~master_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      addr_q  <= '0;
      cmd_q   <= 4'hF;
    end else begin
      frame_q <= frame_n;
      if (start) begin
        addr_q <= ad_in;
        cmd_q  <= cbe_n;
      end
    end
  end

  assign in_win = (addr_q[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]);
  assign io_cmd = (cmd_q == CMD_IO_RD) || (cmd_q == CMD_IO_WR);
  assign hit    = in_win & io_cmd;
  assign is_rd  = (cmd_q == CMD_IO_RD);
  assign offset = addr_q[WIN_BITS-1:0];

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
  import pci_tgt_pkg::*;
#(
  parameter int WAIT_STATES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic hit,
  input  logic frame_n,
  input  logic irdy_n,
  output logic can_start,
  output logic claim,
  output logic trdy_go,
  output logic done,
  output logic devsel_n,
  output logic trdy_n,
  output logic stop_n,
  output logic ctl_oe
);

  localparam int CW = $clog2(WAIT_STATES + 1);

  tgt_state_e    state;
  logic [CW-1:0] cnt;

  assign can_start = (state == ST_IDLE) || (state == ST_TURN);
  assign claim     = (state == ST_DEC) && hit;
  assign trdy_go   = (state == ST_WAIT) && (cnt == '0);
  assign done      = (state == ST_DATA) && !irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      ctl_oe   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_DEC;
        ST_DEC: begin
          if (hit) begin
            devsel_n <= 1'b0;
            ctl_oe   <= 1'b1;
            cnt      <= CW'(WAIT_STATES - 1);
            state    <= ST_WAIT;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (cnt == '0) begin
            trdy_n <= 1'b0;
            stop_n <= frame_n;
            state  <= ST_DATA;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_DATA: begin
          if (!irdy_n) begin
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            state    <= ST_TURN;
          end else begin
            stop_n <= stop_n & frame_n;
          end
        end
        ST_TURN: begin
          ctl_oe <= 1'b0;
          state  <= start ? ST_DEC : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_tgt_data.sv
module pci_tgt_data
  import pci_tgt_pkg::*;
#(
  parameter int WIN_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                claim,
  input  logic                is_rd,
  input  logic                trdy_go,
  input  logic                done,
  input  logic [31:0]         ad_in,
  input  logic [3:0]          cbe_n,
  input  logic [WIN_BITS-1:0] offset,
  input  logic [31:0]         reg_rdata,
  output logic [31:0]         ad_out,
  output logic                ad_oe,
  output logic                par_out,
  output logic                par_oe,
  output logic [WIN_BITS-1:0] reg_addr,
  output logic [3:0]          reg_be,
  output logic                reg_rd,
  output logic                reg_wr,
  output logic [31:0]         reg_wdata
);

  logic rd_q;

  assign reg_addr = offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_be    <= '0;
      reg_wdata <= '0;
      ad_out    <= '0;
      ad_oe     <= 1'b0;
      par_out   <= 1'b0;
      par_oe    <= 1'b0;
    end else begin
      reg_rd <= claim & is_rd;
      reg_wr <= done & ~rd_q;
      if (claim) begin
        rd_q   <= is_rd;
        reg_be <= ~cbe_n;
      end
      if (done && !rd_q) begin
        reg_be    <= ~cbe_n;
        reg_wdata <= ad_in;
      end
      if (reg_rd) ad_out <= reg_rdata;
      if (trdy_go && rd_q) ad_oe <= 1'b1;
      else if (done)       ad_oe <= 1'b0;
      par_oe  <= ad_oe;
      par_out <= even_par(ad_out, cbe_n);
    end
  end

endmodule

// File: rtl/pci_io_target.sv
module pci_io_target
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR   = 32'h0000_C000,
  parameter int          WIN_BITS    = 5,
  parameter int          WAIT_STATES = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_enable,
  input  logic                master_active,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic [3:0]          cbe_n_in,
  input  logic [31:0]         ad_in,
  output logic [31:0]         ad_out,
  output logic                ad_oe,
  output logic                par_out,
  output logic                par_oe,
  output logic                devsel_n_out,
  output logic                trdy_n_out,
  output logic                stop_n_out,
  output logic                ctl_oe,
  output logic [WIN_BITS-1:0] reg_addr,
  output logic [3:0]          reg_be,
  output logic                reg_rd,
  output logic                reg_wr,
  output logic [31:0]         reg_wdata,
  input  logic [31:0]         reg_rdata
);

  logic                can_start, start, hit, is_rd;
  logic                claim, trdy_go, done;
  logic [WIN_BITS-1:0] offset;

  pci_tgt_decode #(.BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS)) u_dec (
    .clk(clk), .rst_n(rst_n), .io_enable(io_enable), .master_active(master_active),
    .frame_n(frame_n), .ad_in(ad_in), .cbe_n(cbe_n_in), .can_start(can_start),
    .start(start), .hit(hit), .is_rd(is_rd), .offset(offset)
  );

  pci_tgt_seq #(.WAIT_STATES(WAIT_STATES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .hit(hit), .frame_n(frame_n),
    .irdy_n(irdy_n), .can_start(can_start), .claim(claim), .trdy_go(trdy_go),
    .done(done), .devsel_n(devsel_n_out), .trdy_n(trdy_n_out),
    .stop_n(stop_n_out), .ctl_oe(ctl_oe)
  );

  pci_tgt_data #(.WIN_BITS(WIN_BITS)) u_dat (
    .clk(clk), .rst_n(rst_n), .claim(claim), .is_rd(is_rd), .trdy_go(trdy_go),
    .done(done), .ad_in(ad_in), .cbe_n(cbe_n_in), .offset(offset),
    .reg_rdata(reg_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out),
    .par_oe(par_oe), .reg_addr(reg_addr), .reg_be(reg_be), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata)
  );

endmodule

// File: rtl/pci_io_target_chk.sv
module pci_io_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_enable,
  input logic       master_active,
  input logic       frame_n,
  input logic       irdy_n,
  input logic [3:0] cbe_n_in,
  input logic       ad_oe,
  input logic       par_oe,
  input logic       devsel_n_out,
  input logic       trdy_n_out,
  input logic       stop_n_out,
  input logic       ctl_oe,
  input logic       reg_rd,
  input logic       reg_wr
);

  a_r1_enable_at_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n_out) |-> $past(io_enable, 2));

  a_r11_no_claim_as_master: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n_out) |-> !$past(master_active, 2));

  a_r2_io_cmd_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n_out) |-> (($past(cbe_n_in, 2) == 4'b0010) || ($past(cbe_n_in, 2) == 4'b0011)));

  a_r3_frame_before_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n_out) |-> !$past(frame_n, 2));

  a_r4_trdy_inside_claim: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n_out |-> (!devsel_n_out && ctl_oe));

  a_r5_rd_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  a_r6_wr_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  a_r7_trdy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n_out && irdy_n) |=> !trdy_n_out);

  a_r8_stop_with_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n_out |-> !trdy_n_out);

  a_r9_par_lags_ad: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |=> par_oe);

  a_r10_release_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n_out) |=> !ctl_oe);

  a_r10_ad_off_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n_out) |-> !ad_oe);

endmodule

bind pci_io_target pci_io_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_enable(io_enable), .master_active(master_active),
  .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n_in(cbe_n_in), .ad_oe(ad_oe),
  .par_oe(par_oe), .devsel_n_out(devsel_n_out), .trdy_n_out(trdy_n_out),
  .stop_n_out(stop_n_out), .ctl_oe(ctl_oe), .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/pci_io_target_tb_top.sv
module pci_io_target_tb_top;

  localparam int W  = 6;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_enable = 1'b1, master_active = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0]  cbe_n_in = 4'hF;
  logic [31:0] ad_in = '0;
  logic [31:0] ad_out, reg_wdata, reg_rdata;
  logic        ad_oe, par_out, par_oe, devsel_n_out, trdy_n_out, stop_n_out, ctl_oe;
  logic [4:0]  reg_addr;
  logic [3:0]  reg_be;
  logic        reg_rd, reg_wr;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [31:0] rmodel(input logic [4:0] o);
    return 32'h1357_9BDF ^ {4{3'b000, o}};
  endfunction

  assign reg_rdata = rmodel(reg_addr);

  pci_io_target #(.BASE_ADDR(32'h0000_C000), .WIN_BITS(5), .WAIT_STATES(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .io_enable(io_enable), .master_active(master_active),
    .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n_in(cbe_n_in), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
    .devsel_n_out(devsel_n_out), .trdy_n_out(trdy_n_out), .stop_n_out(stop_n_out),
    .ctl_oe(ctl_oe), .reg_addr(reg_addr), .reg_be(reg_be), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {burst, claim, irdy delay[3:0], cmd[3:0], be_n[3:0], addr[31:0], wdata[31:0]}
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd0, 4'h2, 4'h0, 32'h0000_C000, 32'h0},
    {1'b0, 1'b1, 4'd0, 4'h3, 4'h0, 32'h0000_C004, 32'hDEAD_BEEF},
    {1'b0, 1'b1, 4'd9, 4'h2, 4'hE, 32'h0000_C01C, 32'h0},
    {1'b0, 1'b1, 4'd3, 4'h3, 4'h7, 32'h0000_C01F, 32'h0123_4567},
    {1'b0, 1'b0, 4'd0, 4'h6, 4'h0, 32'h0000_C000, 32'h0},
    {1'b0, 1'b0, 4'd0, 4'h2, 4'h0, 32'h0000_C020, 32'h0},
    {1'b0, 1'b0, 4'd0, 4'hA, 4'h0, 32'h0000_C008, 32'h0},
    {1'b1, 1'b1, 4'd0, 4'h2, 4'hC, 32'h0000_C010, 32'h0},
    {1'b1, 1'b1, 4'd2, 4'h3, 4'h0, 32'h0000_C008, 32'hA5A5_0F0F},
    {1'b0, 1'b0, 4'd0, 4'h3, 4'h0, 32'h0000_C3E0, 32'h1111_2222}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; drives one access and checks it
  task automatic run_xact(input logic [31:0] addr, input logic [3:0] cmd, input logic [3:0] be_n,
                          input logic [31:0] wd, input int dly, input bit burst, input bit claim,
                          input bit b2b);
    int jd = 0, jt = 0, j = 0;
    bit rd = (cmd == 4'h2);
    logic [4:0]  off = addr[4:0];
    logic [31:0] exp_d = rd ? rmodel(addr[4:0]) : wd;
    frame_n = 1'b0; ad_in = addr; cbe_n_in = cmd; irdy_n = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk); j++;
      if (jd == 0 && !devsel_n_out) jd = j;
      if (!claim) begin
        chk(devsel_n_out && !reg_rd && !reg_wr, "R2/R1/R11 unclaimed access",
            {29'b0, devsel_n_out, reg_rd, reg_wr}, 32'h4);
      end
      if (claim && rd && j == 2) begin
        chk(reg_rd === 1'b1, "R5 read strobe", {31'b0, reg_rd}, 32'h1);
        chk(reg_addr == off, "R12 read offset", {27'b0, reg_addr}, {27'b0, off});
        chk(reg_be == ~be_n, "R5 read byte enables", {28'b0, reg_be}, {28'b0, ~be_n});
      end
      if (claim && rd && j == 3) chk(reg_rd === 1'b0, "R5 read strobe width", {31'b0, reg_rd}, 32'h0);
      if (jt == 0 && !trdy_n_out) begin
        jt = j;
        chk(jt == W + 2, "R4 trdy timing", jt, W + 2);
        chk(stop_n_out == !burst, "R8 stop with trdy", {31'b0, stop_n_out}, {31'b0, !burst});
        if (rd) begin
          chk(ad_oe === 1'b1, "R4 ad_oe", {31'b0, ad_oe}, 32'h1);
          chk(ad_out == exp_d, "R4 read data", ad_out, exp_d);
        end
      end
      if (j == 1) begin
        cbe_n_in = be_n;
        ad_in = rd ? 32'h0 : wd;
        frame_n = burst ? 1'b0 : 1'b1;
      end
      if (j == 1 + dly) irdy_n = 1'b0;
      if (burst && !stop_n_out) frame_n = 1'b1;
      if (!claim && j == 6) begin
        frame_n = 1'b1; irdy_n = 1'b1;
        chk(jd == 0, "R2 no devsel", jd, 0);
        @(posedge clk); @(negedge clk);
        return;
      end
      if (claim && !trdy_n_out && !irdy_n) begin
        @(posedge clk); @(negedge clk); j++;
        irdy_n = 1'b1; frame_n = 1'b1;
        chk(jd == 2, "R3 devsel timing", jd, 2);
        chk(j == ((W + 3 > dly + 2) ? W + 3 : dly + 2), "R7 completion edge", j,
            (W + 3 > dly + 2) ? W + 3 : dly + 2);
        chk(devsel_n_out && trdy_n_out && stop_n_out && ctl_oe && !ad_oe, "R10 driven release",
            {27'b0, devsel_n_out, trdy_n_out, stop_n_out, ctl_oe, ad_oe}, 32'h1E);
        if (rd) begin
          chk(par_oe && (par_out == ^{exp_d, be_n}), "R9 parity",
              {30'b0, par_oe, par_out}, {30'b0, 1'b1, ^{exp_d, be_n}});
        end else begin
          chk(reg_wr === 1'b1, "R6 write strobe", {31'b0, reg_wr}, 32'h1);
          chk(reg_wdata == wd, "R6 write data", reg_wdata, wd);
          chk(reg_be == ~be_n, "R6 write byte enables", {28'b0, reg_be}, {28'b0, ~be_n});
          chk(reg_addr == off, "R12 write offset", {27'b0, reg_addr}, {27'b0, off});
        end
        if (!b2b) begin
          @(posedge clk); @(negedge clk);
          chk(!ctl_oe && !reg_wr, "R10 tri-state after release", {30'b0, ctl_oe, reg_wr}, 32'h0);
        end
        return;
      end
    end
    chk(1'b0, "R7 access never completed", j, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(devsel_n_out && trdy_n_out && stop_n_out && !ctl_oe && !ad_oe && !par_oe && !reg_rd && !reg_wr,
        "R10 reset state",
        {24'b0, devsel_n_out, trdy_n_out, stop_n_out, ctl_oe, ad_oe, par_oe, reg_rd, reg_wr}, 32'hE0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_xact(VEC[i][63:32], VEC[i][71:68], VEC[i][67:64], VEC[i][31:0],
               int'(VEC[i][75:72]), VEC[i][77], VEC[i][76], 1'b0);
      @(negedge clk);
    end

    // R1: I/O space disabled
    io_enable = 1'b0;
    run_xact(32'h0000_C000, 4'h2, 4'h0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    io_enable = 1'b1;
    @(negedge clk);

    // R11: own device is bus master
    master_active = 1'b1;
    run_xact(32'h0000_C004, 4'h3, 4'h0, 32'h5555_AAAA, 0, 1'b0, 1'b0, 1'b0);
    master_active = 1'b0;
    @(negedge clk);

    // R13: next FRAME on the turnaround clock
    run_xact(32'h0000_C00C, 4'h3, 4'h0, 32'hCAFE_F00D, 0, 1'b0, 1'b1, 1'b1);
    run_xact(32'h0000_C014, 4'h2, 4'h0, 32'h0, 1, 1'b0, 1'b1, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule